// File: doc/BRIEF.md
# Seven-Input Ones Counter

This block counts how many of seven input bits are high and presents the result as a 3-bit binary number. The datapath is built only from one-bit full-adder cells arranged as a two-level carry-save tree. No behavioural addition is used in it. Two adders each reduce a group of three inputs. A third adder merges their sums with the seventh input. A fourth adder merges the three carries produced below it.

A parameter chooses between two output modes. In the first, the count is driven straight from the tree. In the second, it passes through a register with a synchronous reset, which gives a clean timing boundary at the cost of one cycle of latency. The block is meant as a small leaf cell for vote counting, bit-population statistics or threshold detection over a 7-bit field.

Top module: `ones7_counter`

## Requirements
- R1: `cnt` equals the number of bits set in `din`, from 0 to 7, as an unsigned binary value with bit 0 the least significant.
- R2: `cnt[0]` is 1 exactly when an odd number of `din` bits are set.
- R3: With `REG_OUT=1`, the value on `cnt` after a rising clock edge is the count of the `din` value sampled at that edge.
- R4: With `REG_OUT=1`, a rising edge with `rst` high makes `cnt` read 0. `cnt` stays 0 for as long as `rst` remains high, whatever `din` is.
- R5: With `REG_OUT=0`, `cnt` follows `din` with no clock edge, and `rst` and `clk` have no effect on it.
- R6: An all-zero `din` gives a count of 0 (`cnt`=3'b000), and an all-ones `din` gives 7 (`cnt`=3'b111).
- R7: Every input position carries equal weight. A `din` with exactly one bit set gives a count of 1 in every one of the seven positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | 7 | Bits to be counted |
| cnt | output | 3 | Number of set bits in `din` |

## Verification
The hardest case to reach is a fault in the final carry-merge adder. That adder only sees all three of its inputs high when both first-level groups and the middle adder produce carries together. This happens only for counts of six and seven, with particular spreads of the set bits across the two groups. For this reason the bench applies every one of the 128 input patterns, checking both the combinational variant and the registered variant. It also applies one-hot and extreme patterns, and it asserts reset while non-zero data is present. This covers the reset clear and the claim that reset has no effect on the combinational variant.

// File: rtl/ones_fa_cell.sv
module ones_fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/ones7_counter.sv
module ones7_counter #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] din,
  output logic [2:0] cnt
);
  localparam int N_IN   = 7;
  localparam int CNT_W  = $clog2(N_IN + 1);
  localparam int GROUPS = 2;

  logic [GROUPS-1:0] grp_s;
  logic [GROUPS-1:0] grp_c;
  logic              mid_c;
  logic [CNT_W-1:0]  tree_cnt;

  for (genvar g = 0; g < GROUPS; g++) begin : g_lvl1
    ones_fa_cell u_fa (
      .x (din[3*g]),
      .y (din[3*g+1]),
      .z (din[3*g+2]),
      .s (grp_s[g]),
      .co(grp_c[g])
    );
  end

  ones_fa_cell u_fa_mid (
    .x (grp_s[0]),
    .y (grp_s[1]),
    .z (din[N_IN-1]),
    .s (tree_cnt[0]),
    .co(mid_c)
  );

  ones_fa_cell u_fa_top (
    .x (grp_c[0]),
    .y (grp_c[1]),
    .z (mid_c),
    .s (tree_cnt[1]),
    .co(tree_cnt[2])
  );

  if (REG_OUT) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= tree_cnt;
    end
    assign cnt = cnt_q;
  end else begin : g_comb
    assign cnt = tree_cnt;
  end
endmodule

// File: rtl/ones7_counter_chk.sv
module ones7_counter_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [6:0] din,
  input logic [2:0] cnt
);
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) prev_rst <= rst;

  // R4
  always @(posedge clk) begin
    if (REG_OUT && prev_rst)
      reset_clear_chk: assert (cnt == 3'd0);
  end

  // R1
  comb_count_chk: assert property (@(posedge clk) disable iff (rst)
    !REG_OUT |-> cnt == 3'($countones(din)));

  // R3
  reg_count_chk: assert property (@(posedge clk) disable iff (rst)
    REG_OUT |=> cnt == 3'($countones($past(din))));

  // R6
  all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && din == 7'h7f) |=> cnt == 3'd7);
endmodule

bind ones7_counter ones7_counter_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .din(din), .cnt(cnt)
);

// File: tb/tb_ones7_counter.sv
module tb_ones7_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] din = '0;
  logic [2:0] cnt_r;
  logic [2:0] cnt_c;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ones7_counter #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .din(din), .cnt(cnt_r)
  );
  ones7_counter #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst(rst), .din(din), .cnt(cnt_c)
  );

  function automatic logic [2:0] ref_ones(input logic [6:0] v);
    logic [2:0] n = '0;
    for (int i = 0; i < 7; i++) n = n + 3'(v[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s din=%b actual=%0d expected=%0d", req, din, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] v, input string req);
    @(negedge clk);
    din = v;
    #1;
    check({req, " comb"}, cnt_c, ref_ones(v));
    @(negedge clk);
    check({req, " reg"}, cnt_r, ref_ones(v));
  endtask

  task automatic t_reset;
    din = 7'h55;
    repeat (2) @(negedge clk);
    check("R4 reset state", cnt_r, 3'd0);
    check("R5 comb ignores reset", cnt_c, 3'd4);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < 128; v++) apply(7'(v), "R1");
  endtask

  task automatic t_parity;
    for (int v = 0; v < 128; v += 9) begin
      @(negedge clk);
      din = 7'(v);
      #1;
      check("R2 parity", {2'b0, cnt_c[0]}, {2'b0, ^din});
    end
  endtask

  task automatic t_onehot;
    for (int i = 0; i < 7; i++) apply(7'(1 << i), "R7 one-hot");
  endtask

  task automatic t_extremes;
    apply(7'h00, "R6 zeros");
    check("R6 zeros value", cnt_r, 3'd0);
    apply(7'h7f, "R6 ones");
    check("R6 ones value", cnt_r, 3'd7);
  endtask

  task automatic t_latency;
    @(negedge clk);
    din = 7'h7f;
    @(negedge clk);
    din = 7'h01;
    #1;
    check("R3 holds prior sample", cnt_r, 3'd7);
    check("R5 comb immediate", cnt_c, 3'd1);
    @(negedge clk);
    check("R3 new sample", cnt_r, 3'd1);
  endtask

  task automatic t_mid_reset;
    apply(7'h3f, "R4 pre");
    rst = 1'b1;
    @(negedge clk);
    check("R4 cleared", cnt_r, 3'd0);
    din = 7'h7e;
    @(negedge clk);
    check("R4 held", cnt_r, 3'd0);
    check("R5 comb during reset", cnt_c, 3'd6);
    rst = 1'b0;
    @(negedge clk);
    check("R3 after release", cnt_r, 3'd6);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_exhaustive();
    t_parity();
    t_onehot();
    t_extremes();
    t_latency();
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule